// File: doc/BRIEF.md
# Regulator Startup Calibration Sequencer

This block orders the digital side of a buck regulator controller's power-up. It stays idle until the enable comparator reports that the enable pin has passed its turn-on level, about 0.7 V. It then runs a calibration of fixed length, counted in microsecond ticks. The first part, 1.1 ms by default, senses the impedance on the compensation pin. On the last tick of that part, the block captures the impedance class as a switching-frequency code. In the same cycle it turns the digitized current-limit voltage into an overcurrent trip code.

Next comes a clamp part, 0.8 ms by default, in which a strobe holds the compensation node low. After that the sequencer waits for the comparator flag showing that the soft-start node has discharged to 0.4 V. It then enters the soft-start phase and gives a one-clock done pulse. The captured settings stay fixed until shutdown. The shutdown comparator, which reports an enable voltage below 270 mV, returns the sequencer to idle from any phase.

Top module: `regstart_cal_seq`

## Requirements
- R1: After reset the phase is idle (code 0), and the frequency code, trip code, protection enable, clamp strobe and done are all 0.
- R2: In idle, the sequencer moves to the sense phase (code 1) one clock after `en_on_i` is high while `en_off_i` is low. Otherwise it stays idle.
- R3: The sense phase lasts exactly SENSE_US ticks of `tick_us_i`. The clamp phase (code 2) follows and lasts exactly CLAMP_US ticks. `comp_clamp_o` is high only in the clamp phase.
- R4: On the final sense tick, the impedance class is decoded into a frequency code: class 0 (open) gives 0 (500 kHz), class 1 (mid resistor) gives 1 (300 kHz), class 2 (low resistor) gives 2 (1 MHz), and class 3 gives 0.
- R5: On the final sense tick, a limit value below OCP_OFF (1 mV per LSB, default 300) sets the trip code to twice the value and sets `ocp_en_o` to 1.
- R6: A sampled limit value of OCP_OFF or more sets `ocp_en_o` to 0 and the trip code to 0.
- R7: After sampling, changes on the impedance class and limit inputs have no effect on the frequency code, trip code or protection enable until shutdown.
- R8: After the clamp phase, the discharge phase (code 3) holds until `ss_low_i` is high. The next clock enters soft-start (code 4).
- R9: `done_o` is high for exactly one clock, in the first cycle of soft-start.
- R10: `en_off_i` high forces the idle phase on the next clock from any phase, and clears the captured settings to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us_i | input | 1 | One-clock pulse every microsecond |
| en_on_i | input | 1 | Enable pin above turn-on level |
| en_off_i | input | 1 | Enable pin below shutdown level |
| ss_low_i | input | 1 | Soft-start node discharged to its start level |
| imp_class_i | input | 2 | Compensation-pin impedance class |
| ilim_mv_i | input | LIM_W | Digitized limit-pin voltage, 1 mV per LSB |
| phase_o | output | 3 | Current phase code |
| fsel_o | output | 2 | Captured switching-frequency code |
| trip_code_o | output | LIM_W+1 | Captured overcurrent trip code |
| ocp_en_o | output | 1 | Overcurrent protection enabled |
| comp_clamp_o | output | 1 | Hold compensation node low |
| done_o | output | 1 | Soft-start entry pulse |

## Verification
The bench builds the block with SENSE_US=11 and CLAMP_US=8 instead of the millisecond defaults. It keeps LIM_W=9 and OCP_OFF=300. The short phases let each run check the tick just before and the tick at each phase boundary. They also allow several complete calibrations in one run, with every impedance class, limit values on both sides of the 300 mV cut-off, and a shutdown in the middle of the sense phase. The real 9-bit limit width keeps the upper limit values, 300 through 511, reachable.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SENSE  = 3'd1,
        PH_CLAMP  = 3'd2,
        PH_DISCH  = 3'd3,
        PH_SSTART = 3'd4
    } phase_e;

    localparam logic [1:0] FSEL_500K = 2'd0;
    localparam logic [1:0] FSEL_300K = 2'd1;
    localparam logic [1:0] FSEL_1M   = 2'd2;

    localparam logic [1:0] IMP_OPEN  = 2'd0;
    localparam logic [1:0] IMP_MID   = 2'd1;
    localparam logic [1:0] IMP_LOW   = 2'd2;

endpackage

// File: rtl/cal_freq_decode.sv
module cal_freq_decode
    import cal_seq_pkg::*;
(
    input  logic [1:0] imp_class_i,
    output logic [1:0] fsel_o
);

    always_comb begin
        case (imp_class_i)
            IMP_MID: fsel_o = FSEL_300K;
            IMP_LOW: fsel_o = FSEL_1M;
            default: fsel_o = FSEL_500K;   // open pin or unknown class
        endcase
    end

endmodule

// File: rtl/cal_limit_eval.sv
module cal_limit_eval #(
    parameter int LIM_W   = 9,
    parameter int OCP_OFF = 300
) (
    input  logic [LIM_W-1:0] lim_i,
    output logic [LIM_W:0]   trip_o,
    output logic             ocp_en_o
);

    localparam logic [LIM_W-1:0] OFF_LVL = LIM_W'(OCP_OFF);

    logic off;

    always_comb begin
        off      = (lim_i >= OFF_LVL);
        ocp_en_o = !off;
        trip_o   = off ? '0 : {lim_i, 1'b0};
    end

endmodule

// File: rtl/cal_phase_timer.sv
module cal_phase_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] term_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             hit;

    always_comb begin
        hit      = (cnt_q == term_i);
        expire_o = run_i && tick_i && hit;
        if (!run_i)
            cnt_d = '0;
        else if (tick_i)
            cnt_d = hit ? '0 : cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    // R3
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q <= term_i));

endmodule

// File: rtl/regstart_cal_seq.sv
module regstart_cal_seq
    import cal_seq_pkg::*;
#(
    parameter int SENSE_US = 1100,
    parameter int CLAMP_US = 800,
    parameter int LIM_W    = 9,
    parameter int OCP_OFF  = 300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_us_i,
    input  logic             en_on_i,
    input  logic             en_off_i,
    input  logic             ss_low_i,
    input  logic [1:0]       imp_class_i,
    input  logic [LIM_W-1:0] ilim_mv_i,
    output logic [2:0]       phase_o,
    output logic [1:0]       fsel_o,
    output logic [LIM_W:0]   trip_code_o,
    output logic             ocp_en_o,
    output logic             comp_clamp_o,
    output logic             done_o
);

    localparam int MAX_US = (SENSE_US > CLAMP_US) ? SENSE_US : CLAMP_US;
    localparam int CNT_W  = (MAX_US > 2) ? $clog2(MAX_US) : 1;
    localparam logic [CNT_W-1:0] SENSE_TERM = CNT_W'(SENSE_US - 1);
    localparam logic [CNT_W-1:0] CLAMP_TERM = CNT_W'(CLAMP_US - 1);

    typedef struct packed {
        phase_e         phase;
        logic [1:0]     fsel;
        logic [LIM_W:0] trip;
        logic           ocp_en;
        logic           done;
    } st_t;

    st_t st_d, st_q;

    logic             run, expire;
    logic [CNT_W-1:0] term;
    logic [1:0]       fsel_new;
    logic [LIM_W:0]   trip_new;
    logic             ocp_new;

    cal_freq_decode u_fdec (
        .imp_class_i (imp_class_i),
        .fsel_o      (fsel_new)
    );

    cal_limit_eval #(.LIM_W(LIM_W), .OCP_OFF(OCP_OFF)) u_lim (
        .lim_i    (ilim_mv_i),
        .trip_o   (trip_new),
        .ocp_en_o (ocp_new)
    );

    assign run  = (st_q.phase == PH_SENSE) || (st_q.phase == PH_CLAMP);
    assign term = (st_q.phase == PH_SENSE) ? SENSE_TERM : CLAMP_TERM;

    cal_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .tick_i   (tick_us_i),
        .term_i   (term),
        .expire_o (expire)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (en_off_i) begin
            st_d = '0;
        end else begin
            case (st_q.phase)
                PH_IDLE:
                    if (en_on_i) st_d.phase = PH_SENSE;
                PH_SENSE:
                    if (expire) begin
                        st_d.phase  = PH_CLAMP;
                        st_d.fsel   = fsel_new;
                        st_d.trip   = trip_new;
                        st_d.ocp_en = ocp_new;
                    end
                PH_CLAMP:
                    if (expire) st_d.phase = PH_DISCH;
                PH_DISCH:
                    if (ss_low_i) begin
                        st_d.phase = PH_SSTART;
                        st_d.done  = 1'b1;
                    end
                PH_SSTART: ;
                default: st_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign phase_o      = st_q.phase;
    assign fsel_o       = st_q.fsel;
    assign trip_code_o  = st_q.trip;
    assign ocp_en_o     = st_q.ocp_en;
    assign comp_clamp_o = (st_q.phase == PH_CLAMP);
    assign done_o       = st_q.done;

    // R10
    shutdown_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_off_i |=> (phase_o == PH_IDLE && !ocp_en_o && trip_code_o == '0));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (phase_o == PH_SSTART && $past(phase_o) == PH_DISCH));

    // R7
    settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_off_i && (phase_o == PH_CLAMP || phase_o == PH_DISCH || phase_o == PH_SSTART))
        |=> ($stable(fsel_o) && $stable(trip_code_o) && $stable(ocp_en_o)));

    // R6
    ocp_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ocp_en_o |-> (trip_code_o == '0));

    // R3
    sense_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_SENSE && !en_off_i) |=> (phase_o == PH_SENSE || phase_o == PH_CLAMP));

    // R8
    disch_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_DISCH && !ss_low_i && !en_off_i) |=> (phase_o == PH_DISCH));

endmodule

// File: tb/regstart_cal_seq_bench.sv
`timescale 1ns/1ps
module regstart_cal_seq_bench;

    localparam int SENSE_US = 11;
    localparam int CLAMP_US = 8;
    localparam int LIM_W    = 9;
    localparam int OCP_OFF  = 300;

    typedef struct {
        string          tag;
        logic [2:0]     phase;
        logic [1:0]     fsel;
        logic [LIM_W:0] trip;
        logic           ocp;
        logic           clamp;
        logic           done;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0, en_on = 1'b0, en_off = 1'b0, ss_low = 1'b0;
    logic [1:0]       imp = 2'd0;
    logic [LIM_W-1:0] ilim = '0;
    logic [2:0]       phase;
    logic [1:0]       fsel;
    logic [LIM_W:0]   trip;
    logic             ocp, clamp, done;

    int   checks = 0;
    int   fails  = 0;
    bit   finished = 0;
    exp_t q[$];

    always #2 clk = ~clk;

    regstart_cal_seq #(.SENSE_US(SENSE_US), .CLAMP_US(CLAMP_US),
                       .LIM_W(LIM_W), .OCP_OFF(OCP_OFF)) u_regstart_cal_seq (
        .clk(clk), .rst_n(rst_n), .tick_us_i(tick), .en_on_i(en_on),
        .en_off_i(en_off), .ss_low_i(ss_low), .imp_class_i(imp),
        .ilim_mv_i(ilim), .phase_o(phase), .fsel_o(fsel), .trip_code_o(trip),
        .ocp_en_o(ocp), .comp_clamp_o(clamp), .done_o(done)
    );

    task automatic push(string tag, logic [2:0] ph, logic [1:0] fs,
                        logic [LIM_W:0] tr, logic oc, logic cl, logic dn);
        exp_t e;
        e.tag = tag; e.phase = ph; e.fsel = fs; e.trip = tr;
        e.ocp = oc; e.clamp = cl; e.done = dn;
        q.push_back(e);
    endtask

    // monitor: compare queued expectations away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (phase !== e.phase || fsel !== e.fsel || trip !== e.trip ||
                    ocp !== e.ocp || clamp !== e.clamp || done !== e.done) begin
                    fails++;
                    $display("FAIL %s: got ph=%0d fs=%0d trip=%0d ocp=%0b clamp=%0b done=%0b, expected ph=%0d fs=%0d trip=%0d ocp=%0b clamp=%0b done=%0b",
                             e.tag, phase, fsel, trip, ocp, clamp, done,
                             e.phase, e.fsel, e.trip, e.ocp, e.clamp, e.done);
                end
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic give_ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    function automatic logic [1:0] exp_fsel(logic [1:0] c);
        return (c == 2'd1) ? 2'd1 : (c == 2'd2) ? 2'd2 : 2'd0;
    endfunction

    function automatic logic exp_ocp(logic [LIM_W-1:0] v);
        return (int'(v) < OCP_OFF);
    endfunction

    function automatic logic [LIM_W:0] exp_trip(logic [LIM_W-1:0] v);
        return exp_ocp(v) ? (LIM_W+1)'(int'(v) * 2) : '0;
    endfunction

    task automatic run_cal(logic [1:0] c, logic [LIM_W-1:0] v);
        logic [1:0]     fs;
        logic [LIM_W:0] tr;
        logic           oc;
        fs = exp_fsel(c); tr = exp_trip(v); oc = exp_ocp(v);
        imp = c; ilim = v;
        en_on = 1'b1;
        step();
        push("R2 idle to sense", 3'd1, 2'd0, '0, 1'b0, 1'b0, 1'b0);
        give_ticks(SENSE_US - 1);
        push("R3 sense one tick before end", 3'd1, 2'd0, '0, 1'b0, 1'b0, 1'b0);
        give_ticks(1);
        push(oc ? "R3 R4 R5 sense end capture" : "R3 R4 R6 sense end capture",
             3'd2, fs, tr, oc, 1'b1, 1'b0);
        imp = ~c; ilim = ~v;
        give_ticks(CLAMP_US - 1);
        push("R7 R3 clamp hold after input change", 3'd2, fs, tr, oc, 1'b1, 1'b0);
        give_ticks(1);
        push("R3 clamp end", 3'd3, fs, tr, oc, 1'b0, 1'b0);
        step(); step();
        push("R8 discharge wait", 3'd3, fs, tr, oc, 1'b0, 1'b0);
        ss_low = 1'b1;
        step();
        push("R8 R9 soft-start entry", 3'd4, fs, tr, oc, 1'b0, 1'b1);
        step();
        push("R9 done one clock", 3'd4, fs, tr, oc, 1'b0, 1'b0);
        en_off = 1'b1; en_on = 1'b0; ss_low = 1'b0;
        step();
        push("R10 shutdown from soft-start", 3'd0, 2'd0, '0, 1'b0, 1'b0, 1'b0);
        en_off = 1'b0;
        step(); step();
        push("R2 idle holds without enable", 3'd0, 2'd0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        step(); step();
        push("R1 reset state", 3'd0, 2'd0, '0, 1'b0, 1'b0, 1'b0);
        step();
        rst_n = 1'b1;
        step();
        push("R1 idle after reset", 3'd0, 2'd0, '0, 1'b0, 1'b0, 1'b0);

        // R2: enable request ignored while shutdown comparator is active
        en_on = 1'b1; en_off = 1'b1;
        step(); step();
        push("R2 shutdown blocks start", 3'd0, 2'd0, '0, 1'b0, 1'b0, 1'b0);
        en_on = 1'b0; en_off = 1'b0;
        step();

        run_cal(2'd0, 9'd100);
        run_cal(2'd1, 9'd299);
        run_cal(2'd2, 9'd300);
        run_cal(2'd3, 9'd6);
        run_cal(2'd2, 9'd511);

        // R10: shutdown in the middle of the sense phase
        imp = 2'd1; ilim = 9'd50; en_on = 1'b1;
        step();
        push("R2 sense before abort", 3'd1, 2'd0, '0, 1'b0, 1'b0, 1'b0);
        give_ticks(3);
        en_off = 1'b1; en_on = 1'b0;
        step();
        push("R10 shutdown from sense", 3'd0, 2'd0, '0, 1'b0, 1'b0, 1'b0);
        en_off = 1'b0;
        step();

        // restart after abort must count a full sense phase again
        run_cal(2'd1, 9'd50);

        step(); step();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule